// File: doc/BRIEF.md
# Dual-I/O SPI Identification Responder

This block is the device-side answer to a read-identification command on a serial flash port running in two-wire mode. It watches chip select and the serial clock, oversampling both with a faster system clock. It collects an 8-bit opcode two bits per serial clock from the two data pins. When the opcode matches and no erase or program is running, it turns the pins around and returns a 3-byte identity, two bits per serial clock.

The identity is a manufacturer byte, then a device-type byte, then a capacity byte. All three are parameters. A busy input stands for an erase or program in progress. While it is set the opcode is not decoded, and the pins are never driven. Raising chip select ends any frame at once and returns the block to standby.

Top module: `dio_id_responder`

## Requirements
- R1: After reset and while chip select is high, `standby` is 1 and `dq_oe` is 0.
- R2: Chip select rising at any point, including in the middle of the ID output, forces `dq_oe` to 0 and `standby` to 1 within three system clocks.
- R3: The opcode is sampled on the rising serial clock edge, two bits per clock. `dq_in[1]` carries bit 7, 5, 3, 1 and `dq_in[0]` carries bit 6, 4, 2, 0, most significant pair first. The accepted value is 0xAF.
- R4: During the first three opcode clocks `dq_oe` stays 0. The pins become outputs only once the last opcode pair is taken.
- R5: After a match, 24 bits are sent as manufacturer, device-type and capacity bytes, each MSB first. They are updated on falling serial clock edges, with `dq_out[1]` on the odd bit and `dq_out[0]` on the even bit of each pair. The first pair is valid at the rising edge after the last opcode clock.
- R6: If `busy` is 1 when the opcode completes, the command is not decoded and `dq_oe` stays 0 for the whole frame.
- R7: A non-matching opcode leaves `dq_oe` at 0 until chip select rises. The next selection is then decoded normally.
- R8: Serial clocks after the 12th output pair give `dq_out` = 00 with `dq_oe` still 1. The output never wraps to the first byte and never continues into further ID data.
- R9: While chip select is low, `standby` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial interface |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| dq_in | input | 2 | Data pin pair as seen at the input buffers |
| busy | input | 1 | Erase or program in progress |
| dq_out | output | 2 | Data pin pair output values |
| dq_oe | output | 1 | Output enable for both data pins |
| standby | output | 1 | High when the block is deselected and waiting |

## Verification
The hardest case to reach is chip select rising in the middle of the identity stream. The pins must release within the same few system clocks, and a later frame must start clean and not resume at the old bit position. The bench stops a frame after five output pairs, checks the release, and then runs a full identification on the next selection. The same reselection check follows the busy case and the rejected-opcode case. Overrun is reached by sending four extra serial clocks after the 24th bit.

// File: rtl/dio_id_responder.sv
module dio_id_responder #(
  parameter logic [7:0] OPCODE   = 8'hAF,
  parameter logic [7:0] MFR_ID   = 8'h20,
  parameter logic [7:0] DEV_TYPE = 8'hBB,
  parameter logic [7:0] CAP_CODE = 8'h18,
  parameter int         ID_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [1:0] dq_in,
  input  logic       busy,
  output logic [1:0] dq_out,
  output logic       dq_oe,
  output logic       standby
);
  localparam int ID_W  = 8 * ID_BYTES;
  localparam int PAIRS = ID_W / 2;
  localparam logic [ID_W-1:0] ID_VAL = {MFR_ID, DEV_TYPE, CAP_CODE};

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_SEND, S_SKIP} st_t;

  st_t             st;
  logic            sck_r, sck_p, cs_r;
  logic [1:0]      dq_r;
  logic [5:0]      op;
  logic [1:0]      bcnt;
  logic [ID_W-1:0] sh;
  logic [4:0]      pcnt;

  wire       rise    = sck_r & ~sck_p;
  wire       fall    = ~sck_r & sck_p;
  wire [7:0] op_full = {op, dq_r};

  assign dq_oe   = (st == S_SEND);
  assign standby = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r  <= 1'b0;
      sck_p  <= 1'b0;
      cs_r   <= 1'b1;
      dq_r   <= 2'b00;
      st     <= S_IDLE;
      op     <= '0;
      bcnt   <= '0;
      sh     <= '0;
      pcnt   <= '0;
      dq_out <= 2'b00;
    end else begin
      sck_r <= sck;
      sck_p <= sck_r;
      cs_r  <= cs_n;
      dq_r  <= dq_in;
      if (cs_r) begin
        st     <= S_IDLE;
        bcnt   <= '0;
        pcnt   <= '0;
        dq_out <= 2'b00;
      end else begin
        case (st)
          S_IDLE: begin
            st   <= S_CMD;
            bcnt <= '0;
          end
          S_CMD: if (rise) begin
            op   <= {op[3:0], dq_r};
            bcnt <= bcnt + 2'd1;
            if (bcnt == 2'd3) begin
              if (op_full == OPCODE && !busy) begin
                st   <= S_SEND;
                sh   <= ID_VAL;
                pcnt <= '0;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_SEND: if (fall) begin
            dq_out <= sh[ID_W-1 -: 2];
            sh     <= {sh[ID_W-3:0], 2'b00};
            if (pcnt != 5'(PAIRS)) pcnt <= pcnt + 5'd1;
          end
          default: ;
        endcase
      end
    end
  end

  // R1 / R2: deselect always leads to standby with pins released
  a_r2_deselect_release: assert property (@(posedge clk) disable iff (!rst_n)
    cs_r |=> (standby && !dq_oe));

  // R6: busy at opcode completion blocks the drive
  a_r6_busy_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && rise && bcnt == 2'd3 && busy) |=> !dq_oe);

  // R7: a rejected frame never turns the pins around
  a_r7_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |=> !dq_oe);

  // R8: after the last pair only zeros leave the block
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && pcnt == 5'(PAIRS) && fall && !cs_r) |=> (dq_out == 2'b00));

  // R5: output starts at the first pair
  a_r5_start_first_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (pcnt == 5'd0));
endmodule

// File: tb/dio_id_responder_tb_top.sv
module dio_id_responder_tb_top;
  localparam logic [7:0] MFR = 8'h20, DEV = 8'hBB, CAP = 8'h18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [1:0] dq_in = 2'b00;
  logic       busy = 1'b0;
  logic [1:0] dq_out;
  logic       dq_oe, standby;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dio_id_responder #(.MFR_ID(MFR), .DEV_TYPE(DEV), .CAP_CODE(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
    .busy(busy), .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clk_pair(input logic [1:0] d, output logic [1:0] q, output logic oe);
    @(negedge clk) dq_in = d;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    q  = dq_out;
    oe = dq_oe;
    sck = 1'b0;
  endtask

  task automatic select();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic deselect();
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // sends opcode; returns oe seen on the first three clocks OR'd together
  task automatic send_op(input logic [7:0] code, output logic early_oe);
    logic [1:0] q;
    logic oe;
    early_oe = 1'b0;
    for (int i = 0; i < 4; i++) begin
      clk_pair(code[7-2*i -: 2], q, oe);
      if (i < 3) early_oe |= oe;
    end
  endtask

  task automatic t_reset();
    chk(standby == 1'b1, "R1 standby after reset", standby, 1);
    chk(dq_oe == 1'b0, "R1 oe after reset", dq_oe, 0);
  endtask

  task automatic t_full_id(input string tag);
    logic early;
    logic [1:0] q;
    logic oe;
    logic [23:0] val = '0;
    bit oe_all = 1;
    select();
    chk(standby == 1'b0, {"R9 standby low ", tag}, standby, 0);
    send_op(8'hAF, early);
    chk(early == 1'b0, {"R4 oe during opcode ", tag}, early, 0);
    for (int k = 0; k < 12; k++) begin
      clk_pair(2'b00, q, oe);
      val = {val[21:0], q};
      oe_all &= oe;
    end
    chk(oe_all, {"R3 oe on after match ", tag}, oe_all, 1);
    chk(val[23:16] == MFR, {"R5 mfr byte ", tag}, val[23:16], MFR);
    chk(val[15:8] == DEV, {"R5 device byte ", tag}, val[15:8], DEV);
    chk(val[7:0] == CAP, {"R5 capacity byte ", tag}, val[7:0], CAP);
    deselect();
    chk(standby && !dq_oe, {"R2 release after frame ", tag}, {standby, dq_oe}, 2);
  endtask

  task automatic t_early_cs();
    logic early;
    logic [1:0] q;
    logic oe;
    select();
    send_op(8'hAF, early);
    for (int k = 0; k < 5; k++) clk_pair(2'b00, q, oe);
    chk(dq_oe == 1'b1, "R2 driving before abort", dq_oe, 1);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dq_oe == 1'b0, "R2 oe released mid output", dq_oe, 0);
    chk(standby == 1'b1, "R2 standby mid output", standby, 1);
    repeat (2) @(negedge clk);
    t_full_id("after abort");
  endtask

  task automatic t_busy();
    logic early;
    logic [1:0] q;
    logic oe;
    bit any = 0;
    busy = 1'b1;
    select();
    send_op(8'hAF, early);
    any = early;
    for (int k = 0; k < 12; k++) begin
      clk_pair(2'b00, q, oe);
      any |= oe;
    end
    chk(any == 1'b0, "R6 no drive while busy", any, 0);
    deselect();
    busy = 1'b0;
    t_full_id("after busy");
  endtask

  task automatic t_bad_op(input logic [7:0] code);
    logic early;
    logic [1:0] q;
    logic oe;
    bit any;
    select();
    send_op(code, early);
    any = early;
    for (int k = 0; k < 12; k++) begin
      clk_pair(2'b11, q, oe);
      any |= oe;
    end
    chk(any == 1'b0, "R7 mismatch keeps pins off", code, 8'hAF);
    deselect();
  endtask

  task automatic t_overrun();
    logic early;
    logic [1:0] q;
    logic oe;
    logic [23:0] val = '0;
    select();
    send_op(8'hAF, early);
    chk(early == 1'b0, "R4 oe off in overrun frame", early, 0);
    for (int k = 0; k < 12; k++) begin
      clk_pair(2'b00, q, oe);
      val = {val[21:0], q};
    end
    chk(val == {MFR, DEV, CAP}, "R3 full id value", val, {MFR, DEV, CAP});
    for (int k = 0; k < 4; k++) begin
      clk_pair(2'b00, q, oe);
      chk(q == 2'b00 && oe == 1'b1, "R8 zeros after id", {oe, q}, 3'b100);
    end
    deselect();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full_id("first");
    t_early_cs();
    t_busy();
    t_bad_op(8'hAE);
    t_bad_op(8'h9F);
    t_full_id("after mismatch");
    t_overrun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule